// File: doc/BRIEF.md
# I2C Bus Status Flag Tracker

This block holds the status flags of an I2C controller that can act as master or as slave. A separate bus engine samples the lines, shifts bits and detects conditions. It passes its findings to this block as single-cycle event pulses: start, repeated start, stop, the ninth-clock acknowledge sample, the end of an address byte with its match results, completion of the second general-call byte, and transfer direction. The block also takes three settings: a software pulse that clears the interrupt flag, an acknowledge-disable level and a general-call-acknowledge-enable level. From these it keeps an 8-bit read-only status word.

Each flag has its own set and clear conditions. A repeated start counts as a start for every flag whose rules involve a start. The status word is registered, so it reflects an event on the clock edge that samples the event. If a set and a clear for the same flag arrive together, the set wins. The one exception is the bus-busy flag, where stop beats start. A synchronous reset clears every flag.

Top module: `i2c_status_tracker`

## Requirements
- R1: While `rst` is high at a clock edge, `statusWord` becomes 0x00 whatever the event inputs are. Bit 5 of `statusWord` always reads 0. The layout from bit 7 down to bit 0 is busy, restart, reserved, lastNack, txMode, addressed, generalCall, firstByte.
- R2: Bit 7 (busy) becomes 1 one cycle after `startDet` or `restartDet`, and 0 one cycle after `stopDet`. When stop and start arrive together, the result is 0.
- R3: Bit 6 (restart) is set by `restartDet`. It is cleared by `intClearWr`, by `stopDet`, or by a rejecting slave address event. An address event with `masterMode`=0 rejects when there is no match and no general call, when `addrMatch`=1 with `ackDisable`=1, or when `addrGeneral`=1 with `gcAckEnable`=0.
- R4: When `ackSampleValid` is high, bit 4 takes the value of `ackSampleSda` (1 = NACK, 0 = ACK). Otherwise any start, repeated start or stop forces it to 0.
- R5: Bit 3 (txMode) is set by `xferValid` with `xferTx`=1. It is cleared by `xferValid` with `xferTx`=0, or by a NACK sample (`ackSampleValid`=1, `ackSampleSda`=1) while `masterMode`=0. A NACK sample in master mode leaves it unchanged.
- R6: Bit 2 (addressed) is set by a slave address event (`addrDone`=1, `masterMode`=0) with `addrMatch`=1 and `ackDisable`=0. It is cleared by any start, repeated start or stop.
- R7: Bit 1 (generalCall) is set in three cases: an address event with `addrGeneral`=1 in slave mode; the same event in master mode with `gcAckEnable`=1; or `gcByte2Done` with `arbLost`=1.
- R8: Bit 1 is cleared by any start, repeated start or stop, or by `gcByte2Done` with `arbLost`=0.
- R9: Bit 0 (firstByte) is set by any start or repeated start. It is cleared by `intClearWr` or by a rejecting slave address event (as in R3). A stop leaves it unchanged.
- R10: For every flag except busy, a set event beats a clear event that arrives in the same cycle.
- R11: An address event with `masterMode`=1 clears neither restart nor firstByte, and it never sets addressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startDet | input | 1 | Start condition pulse |
| restartDet | input | 1 | Repeated start condition pulse |
| stopDet | input | 1 | Stop condition pulse |
| ackSampleValid | input | 1 | Ninth-clock acknowledge sample of a data byte |
| ackSampleSda | input | 1 | SDA level at that sample (1 = NACK) |
| addrDone | input | 1 | Address byte decided |
| addrMatch | input | 1 | Address equals own address |
| addrGeneral | input | 1 | Address is the general call (0x00) |
| masterMode | input | 1 | 1 = master, 0 = slave |
| gcByte2Done | input | 1 | Second general-call byte finished (master) |
| arbLost | input | 1 | Arbitration lost during that byte |
| xferValid | input | 1 | Byte transfer taking place |
| xferTx | input | 1 | Direction of that transfer (1 = transmit) |
| intClearWr | input | 1 | Software writes 0 to the interrupt flag |
| ackDisable | input | 1 | Acknowledge-disable setting |
| gcAckEnable | input | 1 | General-call acknowledge enable setting |
| statusWord | output | 8 | Status flags |

## Verification
The bench builds the block with its default parameters: an 8-bit word, bit 5 reserved, clear-priority only on bit 7, and reset value zero. With these values a single clear-priority cell and a single reserved slot sit next to six set-priority cells. The vector table therefore reaches every variant the generate loop can produce. It then walks one session through slave addressing, rejection for each of the three reasons, master general-call sequences with and without arbitration loss, and colliding set and clear events. The directed tests cover reset applied together with events, and a cycle in which every input is high at once.

// File: rtl/i2c_status_pkg.sv
package i2c_status_pkg;

  localparam int STATUS_W = 8;

  // bit positions; the order is what the register readers decode
  localparam int BIT_BUSY     = 7;
  localparam int BIT_RESTART  = 6;
  localparam int BIT_RSVD     = 5;
  localparam int BIT_LASTNACK = 4;
  localparam int BIT_TXMODE   = 3;
  localparam int BIT_ADDRSD   = 2;
  localparam int BIT_GCALL    = 1;
  localparam int BIT_FIRST    = 0;

  localparam logic [STATUS_W-1:0] RSVD_MASK      = STATUS_W'(1) << BIT_RSVD;
  localparam logic [STATUS_W-1:0] CLR_PRIO_MASK  = STATUS_W'(1) << BIT_BUSY;
  localparam logic [STATUS_W-1:0] STATUS_RST_VAL = '0;

  typedef struct packed {
    logic [STATUS_W-1:0] setVec;
    logic [STATUS_W-1:0] clrVec;
  } flagStrobes_t;

endpackage

// File: rtl/i2c_status_cell.sv
module i2c_status_cell #(
  parameter bit CLEAR_WINS = 1'b0,
  parameter bit RESET_VAL  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic setEv,
  input  logic clrEv,
  output logic flagQ
);

  logic flagNext;

  generate
    if (CLEAR_WINS) begin : g_clrFirst
      always_comb begin
        if (clrEv)      flagNext = 1'b0;
        else if (setEv) flagNext = 1'b1;
        else            flagNext = flagQ;
      end
    end else begin : g_setFirst
      always_comb begin
        if (setEv)      flagNext = 1'b1;
        else if (clrEv) flagNext = 1'b0;
        else            flagNext = flagQ;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) flagQ <= RESET_VAL;
    else     flagQ <= flagNext;
  end

endmodule

// File: rtl/i2c_status_flags.sv
module i2c_status_flags
  import i2c_status_pkg::*;
#(
  parameter int                    WIDTH     = STATUS_W,
  parameter logic [STATUS_W-1:0]   RSVD      = RSVD_MASK,
  parameter logic [STATUS_W-1:0]   CLR_PRIO  = CLR_PRIO_MASK,
  parameter logic [STATUS_W-1:0]   RST_VAL   = STATUS_RST_VAL
) (
  input  logic               clk,
  input  logic               rst,
  input  flagStrobes_t       strobes,
  output logic [WIDTH-1:0]   flagsQ
);

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (RSVD[i]) begin : g_rsvd
        logic unusedStrobe;
        assign unusedStrobe = strobes.setVec[i] ^ strobes.clrVec[i];
        assign flagsQ[i] = 1'b0;
      end else begin : g_flag
        i2c_status_cell #(
          .CLEAR_WINS (CLR_PRIO[i]),
          .RESET_VAL  (RST_VAL[i])
        ) u_cell (
          .clk   (clk),
          .rst   (rst),
          .setEv (strobes.setVec[i]),
          .clrEv (strobes.clrVec[i]),
          .flagQ (flagsQ[i])
        );
      end
    end
  endgenerate

endmodule

// File: rtl/i2c_status_ctrl.sv
module i2c_status_ctrl
  import i2c_status_pkg::*;
(
  input  logic         startDet,
  input  logic         restartDet,
  input  logic         stopDet,
  input  logic         ackSampleValid,
  input  logic         ackSampleSda,
  input  logic         addrDone,
  input  logic         addrMatch,
  input  logic         addrGeneral,
  input  logic         masterMode,
  input  logic         gcByte2Done,
  input  logic         arbLost,
  input  logic         xferValid,
  input  logic         xferTx,
  input  logic         intClearWr,
  input  logic         ackDisable,
  input  logic         gcAckEnable,
  output flagStrobes_t strobes
);

  logic startAny;
  logic slaveAddr;
  logic slaveReject;
  logic gcSeen;
  logic nackSeen;
  logic ackSeen;
  logic slaveNack;

  always_comb begin
    startAny    = startDet | restartDet;
    slaveAddr   = addrDone & ~masterMode;
    // a slave address byte that will not be acknowledged
    slaveReject = slaveAddr & ((~addrMatch & ~addrGeneral) |
                               (addrMatch & ackDisable) |
                               (addrGeneral & ~gcAckEnable));
    gcSeen      = addrDone & addrGeneral & (~masterMode | gcAckEnable);
    nackSeen    = ackSampleValid & ackSampleSda;
    ackSeen     = ackSampleValid & ~ackSampleSda;
    slaveNack   = nackSeen & ~masterMode;
  end

  always_comb begin
    strobes = '0;

    strobes.setVec[BIT_BUSY]     = startAny;
    strobes.clrVec[BIT_BUSY]     = stopDet;

    strobes.setVec[BIT_RESTART]  = restartDet;
    strobes.clrVec[BIT_RESTART]  = intClearWr | slaveReject | stopDet;

    strobes.setVec[BIT_LASTNACK] = nackSeen;
    strobes.clrVec[BIT_LASTNACK] = ackSeen | startAny | stopDet;

    strobes.setVec[BIT_TXMODE]   = xferValid & xferTx;
    strobes.clrVec[BIT_TXMODE]   = (xferValid & ~xferTx) | slaveNack;

    strobes.setVec[BIT_ADDRSD]   = slaveAddr & addrMatch & ~ackDisable;
    strobes.clrVec[BIT_ADDRSD]   = startAny | stopDet;

    strobes.setVec[BIT_GCALL]    = gcSeen | (gcByte2Done & arbLost);
    strobes.clrVec[BIT_GCALL]    = startAny | stopDet | (gcByte2Done & ~arbLost);

    strobes.setVec[BIT_FIRST]    = startAny;
    strobes.clrVec[BIT_FIRST]    = intClearWr | slaveReject;
  end

endmodule

// File: rtl/i2c_status_tracker.sv
module i2c_status_tracker
  import i2c_status_pkg::*;
#(
  parameter logic [STATUS_W-1:0] RSVD     = RSVD_MASK,
  parameter logic [STATUS_W-1:0] CLR_PRIO = CLR_PRIO_MASK,
  parameter logic [STATUS_W-1:0] RST_VAL  = STATUS_RST_VAL
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                startDet,
  input  logic                restartDet,
  input  logic                stopDet,
  input  logic                ackSampleValid,
  input  logic                ackSampleSda,
  input  logic                addrDone,
  input  logic                addrMatch,
  input  logic                addrGeneral,
  input  logic                masterMode,
  input  logic                gcByte2Done,
  input  logic                arbLost,
  input  logic                xferValid,
  input  logic                xferTx,
  input  logic                intClearWr,
  input  logic                ackDisable,
  input  logic                gcAckEnable,
  output logic [STATUS_W-1:0] statusWord
);

  flagStrobes_t strobes;

  i2c_status_ctrl u_ctrl (
    .startDet       (startDet),
    .restartDet     (restartDet),
    .stopDet        (stopDet),
    .ackSampleValid (ackSampleValid),
    .ackSampleSda   (ackSampleSda),
    .addrDone       (addrDone),
    .addrMatch      (addrMatch),
    .addrGeneral    (addrGeneral),
    .masterMode     (masterMode),
    .gcByte2Done    (gcByte2Done),
    .arbLost        (arbLost),
    .xferValid      (xferValid),
    .xferTx         (xferTx),
    .intClearWr     (intClearWr),
    .ackDisable     (ackDisable),
    .gcAckEnable    (gcAckEnable),
    .strobes        (strobes)
  );

  i2c_status_flags #(
    .WIDTH    (STATUS_W),
    .RSVD     (RSVD),
    .CLR_PRIO (CLR_PRIO),
    .RST_VAL  (RST_VAL)
  ) u_flags (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .flagsQ  (statusWord)
  );

endmodule

// File: rtl/i2c_status_checker.sv
module i2c_status_checker (
  input logic       clk,
  input logic       rst,
  input logic       startDet,
  input logic       restartDet,
  input logic       stopDet,
  input logic       ackSampleValid,
  input logic       ackSampleSda,
  input logic       addrDone,
  input logic       addrMatch,
  input logic       masterMode,
  input logic       gcByte2Done,
  input logic       arbLost,
  input logic       xferValid,
  input logic       xferTx,
  input logic       ackDisable,
  input logic [7:0] statusWord
);

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    statusWord[5] == 1'b0);

  a_r2_stop_frees_bus: assert property (@(posedge clk) disable iff (rst)
    stopDet |=> !statusWord[7]);

  a_r2_start_claims_bus: assert property (@(posedge clk) disable iff (rst)
    (startDet || restartDet) && !stopDet |=> statusWord[7]);

  a_r3_restart_flag: assert property (@(posedge clk) disable iff (rst)
    restartDet |=> statusWord[6]);

  a_r3_stop_drops_restart: assert property (@(posedge clk) disable iff (rst)
    stopDet && !restartDet |=> !statusWord[6]);

  a_r4_ack_capture: assert property (@(posedge clk) disable iff (rst)
    ackSampleValid |=> statusWord[4] == $past(ackSampleSda));

  a_r5_direction: assert property (@(posedge clk) disable iff (rst)
    xferValid |=> statusWord[3] == $past(xferTx));

  a_r6_addressed_drop: assert property (@(posedge clk) disable iff (rst)
    (startDet || restartDet || stopDet) &&
    !(addrDone && !masterMode && addrMatch && !ackDisable) |=> !statusWord[2]);

  a_r8_gc_second_clean: assert property (@(posedge clk) disable iff (rst)
    gcByte2Done && !arbLost && !addrDone |=> !statusWord[1]);

  a_r7_gc_arb_lost: assert property (@(posedge clk) disable iff (rst)
    gcByte2Done && arbLost |=> statusWord[1]);

  a_r9_first_byte: assert property (@(posedge clk) disable iff (rst)
    startDet |=> statusWord[0]);

endmodule

bind i2c_status_tracker i2c_status_checker u_chk (
  .clk            (clk),
  .rst            (rst),
  .startDet       (startDet),
  .restartDet     (restartDet),
  .stopDet        (stopDet),
  .ackSampleValid (ackSampleValid),
  .ackSampleSda   (ackSampleSda),
  .addrDone       (addrDone),
  .addrMatch      (addrMatch),
  .masterMode     (masterMode),
  .gcByte2Done    (gcByte2Done),
  .arbLost        (arbLost),
  .xferValid      (xferValid),
  .xferTx         (xferTx),
  .ackDisable     (ackDisable),
  .statusWord     (statusWord)
);

// File: tb/i2c_status_tracker_test.sv
`timescale 1ns/1ps
module i2c_status_tracker_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startDet, restartDet, stopDet, ackSampleValid, ackSampleSda;
  logic addrDone, addrMatch, addrGeneral, masterMode, gcByte2Done, arbLost;
  logic xferValid, xferTx, intClearWr, ackDisable, gcAckEnable;
  logic [7:0] statusWord;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  i2c_status_tracker uut (
    .clk(clk), .rst(rst), .startDet(startDet), .restartDet(restartDet),
    .stopDet(stopDet), .ackSampleValid(ackSampleValid), .ackSampleSda(ackSampleSda),
    .addrDone(addrDone), .addrMatch(addrMatch), .addrGeneral(addrGeneral),
    .masterMode(masterMode), .gcByte2Done(gcByte2Done), .arbLost(arbLost),
    .xferValid(xferValid), .xferTx(xferTx), .intClearWr(intClearWr),
    .ackDisable(ackDisable), .gcAckEnable(gcAckEnable), .statusWord(statusWord)
  );

  // stimulus bit masks
  localparam logic [15:0] S_START   = 16'h8000;
  localparam logic [15:0] S_RESTART = 16'h4000;
  localparam logic [15:0] S_STOP    = 16'h2000;
  localparam logic [15:0] S_ACKV    = 16'h1000;
  localparam logic [15:0] S_ACKSDA  = 16'h0800;
  localparam logic [15:0] S_ADDR    = 16'h0400;
  localparam logic [15:0] S_AMATCH  = 16'h0200;
  localparam logic [15:0] S_AGEN    = 16'h0100;
  localparam logic [15:0] S_MASTER  = 16'h0080;
  localparam logic [15:0] S_GC2     = 16'h0040;
  localparam logic [15:0] S_ARB     = 16'h0020;
  localparam logic [15:0] S_XV      = 16'h0010;
  localparam logic [15:0] S_XTX     = 16'h0008;
  localparam logic [15:0] S_ICLR    = 16'h0004;
  localparam logic [15:0] S_ACKDIS  = 16'h0002;
  localparam logic [15:0] S_GCEN    = 16'h0001;

  localparam int NVEC = 30;
  // {stimulus, expected status, requirement number}
  localparam logic [31:0] VEC [NVEC] = '{
    {S_START,                         8'h81, 8'd2},
    {S_ADDR|S_AMATCH,                 8'h85, 8'd6},
    {S_XV|S_XTX,                      8'h8D, 8'd5},
    {S_ACKV,                          8'h8D, 8'd4},
    {S_ACKV|S_ACKSDA,                 8'h95, 8'd5},
    {S_XV|S_XTX,                      8'h9D, 8'd5},
    {S_XV,                            8'h95, 8'd5},
    {S_RESTART,                       8'hC1, 8'd3},
    {S_ADDR,                          8'h80, 8'd3},
    {S_RESTART,                       8'hC1, 8'd2},
    {S_ADDR|S_AMATCH|S_ACKDIS,        8'h80, 8'd6},
    {S_RESTART,                       8'hC1, 8'd3},
    {S_ADDR|S_AGEN,                   8'h82, 8'd7},
    {S_RESTART,                       8'hC1, 8'd8},
    {S_ADDR|S_AGEN|S_GCEN,            8'hC3, 8'd7},
    {S_ICLR,                          8'h82, 8'd9},
    {S_STOP,                          8'h00, 8'd2},
    {S_START|S_STOP,                  8'h01, 8'd2},
    {S_START|S_MASTER,                8'h81, 8'd9},
    {S_ADDR|S_AGEN|S_MASTER,          8'h81, 8'd11},
    {S_ADDR|S_AGEN|S_MASTER|S_GCEN,   8'h83, 8'd7},
    {S_GC2|S_MASTER,                  8'h81, 8'd8},
    {S_GC2|S_ARB|S_MASTER,            8'h83, 8'd7},
    {S_ADDR|S_MASTER,                 8'h83, 8'd11},
    {S_XV|S_XTX|S_MASTER,             8'h8B, 8'd5},
    {S_ACKV|S_ACKSDA|S_MASTER,        8'h9B, 8'd5},
    {S_RESTART|S_ICLR,                8'hC9, 8'd10},
    {S_ACKV|S_ACKSDA|S_START,         8'hD1, 8'd10},
    {S_STOP,                          8'h01, 8'd9},
    {S_ICLR,                          8'h00, 8'd9}
  };

  function automatic string reqName(input int id);
    case (id)
      1:  return "R1";
      2:  return "R2";
      3:  return "R3";
      4:  return "R4";
      5:  return "R5";
      6:  return "R6";
      7:  return "R7";
      8:  return "R8";
      9:  return "R9";
      10: return "R10";
      11: return "R11";
      default: return "R?";
    endcase
  endfunction

  task automatic driveStim(input logic [15:0] s);
    {startDet, restartDet, stopDet, ackSampleValid, ackSampleSda, addrDone,
     addrMatch, addrGeneral, masterMode, gcByte2Done, arbLost, xferValid,
     xferTx, intClearWr, ackDisable, gcAckEnable} = s;
  endtask

  task automatic checkStatus(input logic [7:0] exp, input string req, input int tag);
    checks++;
    if (statusWord !== exp) begin
      fails++;
      $display("FAIL %s step %0d: statusWord=%02h expected %02h", req, tag, statusWord, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    finishRun();
  end

  initial begin
    driveStim(16'h0000);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    checkStatus(8'h00, "R1", 0);          // reset state
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      driveStim(VEC[i][31:16]);
      @(negedge clk);
      checkStatus(VEC[i][15:8], reqName(int'(VEC[i][7:0])), i + 1);
    end

    // R1: reset wins over events arriving in the same cycle
    driveStim(S_START | S_RESTART | S_ADDR | S_AMATCH);
    rst = 1'b1;
    @(negedge clk);
    checkStatus(8'h00, "R1", 100);
    rst = 1'b0;
    driveStim(16'h0000);
    @(negedge clk);
    checkStatus(8'h00, "R1", 101);

    // R1/R10: every input high at once; bit 5 stays 0, busy loses to stop
    driveStim(16'hFFFF);
    @(negedge clk);
    checkStatus(8'h5B, "R10", 102);
    checks++;
    if (statusWord[5] !== 1'b0) begin
      fails++;
      $display("FAIL R1 reserved bit: actual %b expected 0", statusWord[5]);
    end

    driveStim(16'h0000);
    rst = 1'b1;
    @(negedge clk);
    checkStatus(8'h00, "R1", 103);
    rst = 1'b0;

    finishRun();
  end

endmodule